// File: doc/BRIEF.md
# Stop-Clock SPI Serial Port

This block is a word-oriented synchronous serial port for a link in which the shift clock runs only while a word is in flight. One instance can lead the link or follow it, and the mode input picks which. When it leads, it drives the shift clock, an active-low select and the outgoing data. It also captures the incoming data. When it follows, it takes the clock and select from the other end, and it tri-states its data pin whenever the select is not asserted.

Words of `WORD_W` bits move most-significant bit first in both directions at once. Outgoing data changes only after a falling clock edge, and incoming data is captured on the rising edge. The clock rests low between words. On the parallel side, a transmit word enters through a valid/ready handshake and a received word leaves with a one-cycle valid strobe.

In master mode an accepted word starts a transfer at once. In slave mode an accepted word is armed and goes out at the next select. A follower that has no word armed answers with zeros.

Top module: `spi_cs_port`

## Requirements
- R1: In master mode an accepted word drives `ss_n_o` low, produces exactly `WORD_W` rising edges on `sclk_o`, and then returns `ss_n_o` high. `sclk_o` is low whenever `ss_n_o` is high.
- R2: In master mode each clock half-period lasts `HALF_DIV` system clocks. The first rising edge of `sclk_o` comes `HALF_DIV` system clocks after `ss_n_o` falls.
- R3: In master mode `sd_o` carries the MSB from the cycle `ss_n_o` falls, changes only after falling edges of `sclk_o`, and sends bit `WORD_W-1` down to bit 0.
- R4: In master mode `sd_i` is captured at each rising edge of `sclk_o`. The first bit captured becomes bit `WORD_W-1` of `rx_data_o`.
- R5: `rx_valid_o` is a single-cycle pulse that rises one system clock after the last bit of a word is captured, with `rx_data_o` holding the word. In master mode the pulse coincides with the first cycle of the last high clock phase.
- R6: In master mode `sd_oe_o` is high for as long as `ss_n_o` is low. It falls together with the rise of `ss_n_o`, half a clock period after the last rising edge.
- R7: `tx_ready_o` is low while a master transfer runs, while a slave word is armed, and while a slave transfer runs. A word offered during that time waits and is not lost.
- R8: In slave mode `ss_n_i`, `sclk_i` and `sd_i` are sampled every `SLV_DIV` system clocks through `SYNC_STAGES` registers. After `ss_n_i` falls, `sd_oe_o` goes high and `sd_o` shows the armed MSB before the first rising edge of `sclk_i`.
- R9: In slave mode the next bit appears on `sd_o` after each falling edge of `sclk_i` within the word. `sd_i` is captured on rising edges, and a received word is delivered after `WORD_W` rising edges.
- R10: In slave mode `sd_oe_o` stays high after the last clock edge and drops only after `ss_n_i` returns high.
- R11: In slave mode a select that arrives with no armed word transmits all zeros.
- R12: `mst_mode_i` = 1 selects master and 0 selects slave. The mode is taken only while idle. In master mode the slave inputs `ss_n_i`/`sclk_i` have no effect. In slave mode `sclk_o` stays low and `ss_n_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_mode_i | input | 1 | 1 = master, 0 = slave; taken while idle |
| tx_data_i | input | WORD_W | Word to transmit |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Port can take a transmit word |
| rx_data_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| sclk_o | output | 1 | Shift clock driven as master |
| ss_n_o | output | 1 | Active-low select driven as master |
| sclk_i | input | 1 | Shift clock from external master |
| ss_n_i | input | 1 | Active-low select from external master |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Output enable for `sd_o` (low = high impedance) |

## Verification
The bench runs master words whose first and last bits are the only set bits, as well as all-ones and alternating patterns. A design that shifts on the wrong edge or sends LSB first returns a word that is mirrored or shifted by one. It counts clock rises and high-phase lengths per frame, so an extra or missing clock, or an early first edge after select, shows up as a count mismatch. A second word is held on the handshake during a master frame, and a design that drops or overwrites it sends the wrong word next. On the slave side the bench checks that the data pin stays enabled after the last clock until select is released, that an unarmed select sends zeros, and that clocking the slave pins in master mode produces no output enable and no received word.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

   typedef enum logic {
      ROLE_SLAVE  = 1'b0,
      ROLE_MASTER = 1'b1
   } role_e;

   // layout of the sampled slave-pin vector
   localparam int SYN_W  = 3;
   localparam int SYN_SS = 2;
   localparam int SYN_CK = 1;
   localparam int SYN_DI = 0;
   localparam logic [SYN_W-1:0] SYN_IDLE = 3'b100;

endpackage

// File: rtl/spi_cs_tick.sv
module spi_cs_tick #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);

   if (DIV < 1) begin : g_bad_div
      $error("spi_cs_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick = en;
   end else begin : g_count
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;

      assign tick = en && (cnt == CW'(DIV - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (!en || tick)
            cnt <= '0;
         else
            cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/spi_cs_sync.sv
module spi_cs_sync #(
   parameter int           W       = 3,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         fresh
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_cs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= {STAGES{RST_VAL}};
         fresh <= 1'b0;
      end else begin
         fresh <= tick;
         if (tick)
            st <= {st[STAGES-2:0], d};
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/spi_cs_shreg.sv
module spi_cs_shreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         sample,
   input  logic         sbit,
   output logic         tx_msb,
   output logic [W-1:0] rx_next
);

   logic [W-1:0] tx_sr;
   logic [W-2:0] rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_sr <= '0;
      else if (load)
         tx_sr <= load_val;
      else if (shift)
         tx_sr <= {tx_sr[W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_sr <= '0;
      else if (sample)
         rx_sr <= rx_next[W-2:0];
   end

   assign tx_msb  = tx_sr[W-1];
   assign rx_next = {rx_sr, sbit};

endmodule

// File: rtl/spi_cs_port.sv
module spi_cs_port
   import spi_cs_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int HALF_DIV    = 2,
   parameter int SLV_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mst_mode_i,
   input  logic [WORD_W-1:0] tx_data_i,
   input  logic              tx_valid_i,
   output logic              tx_ready_o,
   output logic [WORD_W-1:0] rx_data_o,
   output logic              rx_valid_o,
   output logic              sclk_o,
   output logic              ss_n_o,
   input  logic              sclk_i,
   input  logic              ss_n_i,
   input  logic              sd_i,
   output logic              sd_o,
   output logic              sd_oe_o
);

   if (WORD_W < 2) begin : g_bad_word
      $error("spi_cs_port: WORD_W must be at least 2");
   end
   if (HALF_DIV < 1) begin : g_bad_half
      $error("spi_cs_port: HALF_DIV must be at least 1");
   end
   if (SLV_DIV < 1) begin : g_bad_slv
      $error("spi_cs_port: SLV_DIV must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_cs_port: SYNC_STAGES must be at least 2");
   end

   localparam int CW = $clog2(WORD_W + 1);
   localparam int PW = $clog2(2 * WORD_W + 1);
   localparam logic [PW-1:0] PH_LAST  = PW'(2 * WORD_W - 1);
   localparam logic [PW-1:0] PH_LSAMP = PW'(2 * WORD_W - 2);
   localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);
   localparam logic [CW-1:0] CNT_LAST = CW'(WORD_W - 1);

   role_e role_q;
   logic  is_slave;
   logic  accept;

   // master side state
   logic          m_busy;
   logic [PW-1:0] m_ph;
   logic          m_sclk_q;
   logic          m_fs_q;
   logic          m_oe_q;
   logic          m_tick;
   logic          m_start, m_shift, m_sample, m_last;

   // slave side state
   logic             s_busy;
   logic             s_armed;
   logic             s_oe_q;
   logic [CW-1:0]    s_cnt;
   logic [SYN_W-1:0] syn_q;
   logic             syn_fresh;
   logic             s_tick;
   logic [1:0]       ctl_prev;
   logic             sel_now, sel_was, ck_now, ck_was, ev_gate;
   logic             ev_sel_on, ev_sel_off, ev_ck_rise, ev_ck_fall;
   logic             s_arm, s_zero, s_shift, s_sample, s_last;

   // shared shifter controls
   logic              sh_load, sh_shift, sh_sample, sh_bit;
   logic [WORD_W-1:0] sh_val;
   logic [WORD_W-1:0] rx_next;
   logic              tx_msb;

   assign is_slave   = (role_q == ROLE_SLAVE);
   assign tx_ready_o = !m_busy && !s_busy && !s_armed && !ev_sel_on;
   assign accept     = tx_valid_i && tx_ready_o;

   // mode is latched only when nothing is pending or starting
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         role_q <= ROLE_SLAVE;
      else if (!m_busy && !s_busy && !s_armed && !accept && !ev_sel_on)
         role_q <= mst_mode_i ? ROLE_MASTER : ROLE_SLAVE;
   end

   // ---------------- master ----------------
   spi_cs_tick #(.DIV(HALF_DIV)) u_half_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (m_busy),
      .tick  (m_tick)
   );

   assign m_start  = accept && !is_slave;
   assign m_sample = m_busy && m_tick && !m_ph[0];
   assign m_shift  = m_busy && m_tick && m_ph[0] && (m_ph != PH_LAST);
   assign m_last   = m_sample && (m_ph == PH_LSAMP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy   <= 1'b0;
         m_ph     <= '0;
         m_sclk_q <= 1'b0;
         m_fs_q   <= 1'b0;
         m_oe_q   <= 1'b0;
      end else if (m_start) begin
         m_busy   <= 1'b1;
         m_ph     <= '0;
         m_sclk_q <= 1'b0;
         m_fs_q   <= 1'b1;
         m_oe_q   <= 1'b1;
      end else if (m_busy && m_tick) begin
         m_ph <= m_ph + 1'b1;
         if (!m_ph[0]) begin
            m_sclk_q <= 1'b1;
         end else begin
            m_sclk_q <= 1'b0;
            if (m_ph == PH_LAST) begin
               m_busy <= 1'b0;
               m_fs_q <= 1'b0;
               m_oe_q <= 1'b0;
            end
         end
      end
   end

   // ---------------- slave ----------------
   spi_cs_tick #(.DIV(SLV_DIV)) u_slv_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (1'b1),
      .tick  (s_tick)
   );

   spi_cs_sync #(
      .W       (SYN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYN_IDLE)
   ) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (s_tick),
      .d     ({ss_n_i, sclk_i, sd_i}),
      .q     (syn_q),
      .fresh (syn_fresh)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_prev <= 2'b10;
      else if (syn_fresh)
         ctl_prev <= {syn_q[SYN_SS], syn_q[SYN_CK]};
   end

   assign sel_now    = !syn_q[SYN_SS];
   assign sel_was    = !ctl_prev[1];
   assign ck_now     = syn_q[SYN_CK];
   assign ck_was     = ctl_prev[0];
   assign ev_gate    = syn_fresh && is_slave;
   assign ev_sel_on  = ev_gate && sel_now && !sel_was;
   assign ev_sel_off = ev_gate && !sel_now && sel_was;
   assign ev_ck_rise = ev_gate && sel_now && ck_now && !ck_was;
   assign ev_ck_fall = ev_gate && sel_now && !ck_now && ck_was;

   assign s_arm    = accept && is_slave;
   assign s_zero   = ev_sel_on && !s_armed;
   assign s_sample = ev_ck_rise && s_busy && (s_cnt < CNT_FULL);
   assign s_shift  = ev_ck_fall && s_busy && (s_cnt != '0) && (s_cnt < CNT_FULL);
   assign s_last   = s_sample && (s_cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_busy  <= 1'b0;
         s_armed <= 1'b0;
         s_oe_q  <= 1'b0;
         s_cnt   <= '0;
      end else begin
         if (s_arm)
            s_armed <= 1'b1;
         if (ev_sel_on) begin
            s_busy  <= 1'b1;
            s_oe_q  <= 1'b1;
            s_cnt   <= '0;
            s_armed <= 1'b0;
         end else if (ev_sel_off) begin
            s_busy <= 1'b0;
            s_oe_q <= 1'b0;
         end else if (s_sample) begin
            s_cnt <= s_cnt + 1'b1;
         end
      end
   end

   // ---------------- shared datapath ----------------
   assign sh_load   = m_start || s_arm || s_zero;
   assign sh_val    = s_zero ? '0 : tx_data_i;
   assign sh_shift  = m_shift || s_shift;
   assign sh_sample = m_sample || s_sample;
   assign sh_bit    = is_slave ? syn_q[SYN_DI] : sd_i;

   spi_cs_shreg #(.W(WORD_W)) u_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (sh_val),
      .shift    (sh_shift),
      .sample   (sh_sample),
      .sbit     (sh_bit),
      .tx_msb   (tx_msb),
      .rx_next  (rx_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid_o <= 1'b0;
         rx_data_o  <= '0;
      end else begin
         rx_valid_o <= m_last || s_last;
         if (m_last || s_last)
            rx_data_o <= rx_next;
      end
   end

   assign sclk_o  = m_sclk_q;
   assign ss_n_o  = !m_fs_q;
   assign sd_o    = tx_msb;
   assign sd_oe_o = m_oe_q || s_oe_q;

endmodule

// File: rtl/spi_cs_port_chk.sv
module spi_cs_port_chk #(
   parameter int WORD_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic tx_ready_o,
   input logic rx_valid_o,
   input logic sclk_o,
   input logic ss_n_o,
   input logic ss_n_i,
   input logic sd_o,
   input logic sd_oe_o
);

   localparam int RW = $clog2(WORD_W + 2);

   logic [RW-1:0] rises_q;
   logic          sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rises_q <= '0;
         sclk_d  <= 1'b0;
      end else begin
         sclk_d <= sclk_o;
         if (ss_n_o)
            rises_q <= '0;
         else if (sclk_o && !sclk_d)
            rises_q <= rises_q + 1'b1;
      end
   end

   assert_idle_clock_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n_o |-> !sclk_o);

   assert_edge_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_n_o) |-> (rises_q == RW'(WORD_W)));

   assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> $stable(sd_o));

   assert_rx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   assert_rx_at_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_o && !ss_n_o) |-> $rose(sclk_o));

   assert_oe_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_n_o |-> sd_oe_o);

   assert_oe_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_n_o) |-> $fell(sd_oe_o));

   assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_n_o |-> !tx_ready_o);

   assert_slave_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sd_oe_o) && ss_n_o && $past(ss_n_o)) |-> ss_n_i);

endmodule

bind spi_cs_port spi_cs_port_chk #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_ready_o (tx_ready_o),
   .rx_valid_o (rx_valid_o),
   .sclk_o     (sclk_o),
   .ss_n_o     (ss_n_o),
   .ss_n_i     (ss_n_i),
   .sd_o       (sd_o),
   .sd_oe_o    (sd_oe_o)
);

// File: tb/spi_cs_port_bench.sv
`timescale 1ns/1ps
module spi_cs_port_bench;

   localparam int W  = 8;
   localparam int HD = 3;
   localparam int SD = 4;
   localparam int SH = 24;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mst_mode_i = 1'b1;
   logic [W-1:0] tx_data_i = '0;
   logic         tx_valid_i = 1'b0;
   logic         tx_ready_o;
   logic [W-1:0] rx_data_o;
   logic         rx_valid_o;
   logic         sclk_o, ss_n_o, sd_o, sd_oe_o;
   logic         sclk_i = 1'b0;
   logic         ss_n_i = 1'b1;
   logic         sd_i = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   int role_bad = 0;
   int rxv_cnt = 0;
   logic [W-1:0] rxv_last = '0;
   bit wd_hit = 0;

   always #5 clk = ~clk;

   spi_cs_port #(
      .WORD_W(W), .HALF_DIV(HD), .SLV_DIV(SD), .SYNC_STAGES(2)
   ) u_spi_cs_port (
      .clk(clk), .rst_n(rst_n), .mst_mode_i(mst_mode_i),
      .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
      .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
      .sclk_o(sclk_o), .ss_n_o(ss_n_o), .sclk_i(sclk_i), .ss_n_i(ss_n_i),
      .sd_i(sd_i), .sd_o(sd_o), .sd_oe_o(sd_oe_o)
   );

   always @(negedge clk) begin
      if (rx_valid_o) begin
         rxv_cnt  <= rxv_cnt + 1;
         rxv_last <= rx_data_o;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) begin
         @(negedge clk);
         if (sclk_o || !ss_n_o) role_bad++;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(ss_n_o == 1'b1, "R1", "reset ss_n_o", ss_n_o, 1);
      check(sclk_o == 1'b0, "R1", "reset sclk_o", sclk_o, 0);
      check(sd_oe_o == 1'b0, "R6", "reset sd_oe_o", sd_oe_o, 0);
      check(rx_valid_o == 1'b0, "R5", "reset rx_valid_o", rx_valid_o, 0);
      check(tx_ready_o == 1'b1, "R7", "reset tx_ready_o", tx_ready_o, 1);
   endtask

   // master transfer: val out, miso returned by the bench as far end
   task automatic m_xfer(input logic [W-1:0] val, input logic [W-1:0] miso,
                         input bit hold, input logic [W-1:0] nxt);
      int rises = 0, cyc = 0, first = -1, hi = 0, hi_bad = 0, ready_bad = 0;
      int rx0;
      bit prev = 1'b0, rx_at_last = 1'b0, rx_early = 1'b0;
      logic [W-1:0] got = '0, rx_d = '0;
      sd_i       = miso[W-1];
      tx_data_i  = val;
      tx_valid_i = 1'b1;
      while (!tx_ready_o) @(negedge clk);
      @(negedge clk);
      if (hold) tx_data_i = nxt;
      else tx_valid_i = 1'b0;
      check(ss_n_o == 1'b0, "R1", "select after accept", ss_n_o, 0);
      check(sd_oe_o == 1'b1, "R6", "oe after accept", sd_oe_o, 1);
      check(sd_o == val[W-1], "R3", "msb before first edge", sd_o, val[W-1]);
      check(tx_ready_o == 1'b0, "R7", "ready during frame", tx_ready_o, 0);
      rx0 = rxv_cnt;
      while (!ss_n_o && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         if (!ss_n_o && tx_ready_o) ready_bad++;
         if (sclk_o && !prev) begin
            rises++;
            if (rises == 1) first = cyc;
            got = {got[W-2:0], sd_o};
            if (rises == W) begin
               rx_at_last = rx_valid_o;
               rx_d = rx_data_o;
            end else if (rx_valid_o) begin
               rx_early = 1'b1;
            end
            hi = 0;
         end
         if (sclk_o) hi++;
         if (!sclk_o && prev) begin
            if (hi != HD) hi_bad++;
            if (rises < W) sd_i = miso[W-1-rises];
         end
         prev = sclk_o;
      end
      check(rises == W, "R1", "rising edges per word", rises, W);
      check(first == HD, "R2", "select to first edge", first, HD);
      check(hi_bad == 0, "R2", "high phase length errors", hi_bad, 0);
      check(got == val, "R3", "serialised word", got, val);
      check(rx_at_last && rx_d == miso, "R4", "received word", rx_d, miso);
      check(!rx_early, "R5", "early rx strobe", rx_early, 0);
      check(sd_oe_o == 1'b0, "R6", "oe at select release", sd_oe_o, 0);
      check(ready_bad == 0, "R7", "ready high inside frame", ready_bad, 0);
      wait_n(2);
      check(rxv_cnt - rx0 == 1, "R5", "strobe count", rxv_cnt - rx0, 1);
   endtask

   // slave transfer: bench is the far master
   task automatic s_xfer(input bit arm, input logic [W-1:0] val, input logic [W-1:0] mosi);
      logic [W-1:0] exp, got;
      int rx0;
      exp = arm ? val : '0;
      got = '0;
      if (arm) begin
         tx_data_i  = val;
         tx_valid_i = 1'b1;
         while (!tx_ready_o) @(negedge clk);
         @(negedge clk);
         tx_valid_i = 1'b0;
         check(tx_ready_o == 1'b0, "R7", "ready while armed", tx_ready_o, 0);
         check(sd_oe_o == 1'b0, "R8", "oe before select", sd_oe_o, 0);
      end
      rx0    = rxv_cnt;
      sd_i   = mosi[W-1];
      ss_n_i = 1'b0;
      wait_n(SH);
      check(sd_oe_o == 1'b1, "R8", "oe after select", sd_oe_o, 1);
      check(sd_o == exp[W-1], arm ? "R8" : "R11", "first bit", sd_o, exp[W-1]);
      for (int i = 0; i < W; i++) begin
         got = {got[W-2:0], sd_o};
         sclk_i = 1'b1;
         wait_n(SH);
         sclk_i = 1'b0;
         if (i < W - 1) sd_i = mosi[W-2-i];
         wait_n(SH);
      end
      check(rxv_cnt - rx0 == 1, "R9", "slave strobe count", rxv_cnt - rx0, 1);
      check(rxv_last == mosi, "R9", "slave received word", rxv_last, mosi);
      check(got == exp, arm ? "R9" : "R11", "slave sent word", got, exp);
      check(sd_oe_o == 1'b1, "R10", "oe held after last edge", sd_oe_o, 1);
      ss_n_i = 1'b1;
      wait_n(SH);
      check(sd_oe_o == 1'b0, "R10", "oe after deselect", sd_oe_o, 0);
      check(tx_ready_o == 1'b1, "R7", "ready after slave frame", tx_ready_o, 1);
   endtask

   task automatic t_ignore_slave_pins();
      int oe_seen = 0;
      int rx0 = rxv_cnt;
      ss_n_i = 1'b0;
      for (int k = 0; k < 2 * W; k++) begin
         repeat (8) begin
            @(negedge clk);
            if (sd_oe_o || !ss_n_o) oe_seen++;
         end
         sclk_i = ~sclk_i;
         sd_i   = k[0];
      end
      ss_n_i = 1'b1;
      sclk_i = 1'b0;
      repeat (16) begin
         @(negedge clk);
         if (sd_oe_o || !ss_n_o) oe_seen++;
      end
      check(oe_seen == 0, "R12", "slave pins drove outputs in master mode", oe_seen, 0);
      check(rxv_cnt == rx0, "R12", "rx strobe from slave pins in master mode", rxv_cnt - rx0, 0);
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      m_xfer(8'hA5, 8'h3C, 1'b0, '0);
      m_xfer(8'h80, 8'h01, 1'b0, '0);
      m_xfer(8'hFF, 8'h00, 1'b1, 8'h5A);
      m_xfer(8'h5A, 8'hC3, 1'b0, '0);
      m_xfer(8'h01, 8'h80, 1'b0, '0);
      t_ignore_slave_pins();
      mst_mode_i = 1'b0;
      repeat (20) @(negedge clk);
      role_bad = 0;
      s_xfer(1'b1, 8'h96, 8'h69);
      s_xfer(1'b0, 8'h00, 8'hF0);
      s_xfer(1'b1, 8'h01, 8'h80);
      check(role_bad == 0, "R12", "master pins active in slave mode", role_bad, 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            wd_hit = 1'b1;
         end
      join_any
      disable fork;
      if (wd_hit) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule